// File: doc/BRIEF.md
# Coprocessor Host Register Interface

This block sits between a host processor bus and a motor-control coprocessor. It decodes a 4-bit register address qualified by separate single-cycle read and write strobes. It holds a read/write mode and enable word and a read-only event status word. Its outputs include the mode bits, an active-low interrupt line, a clock-enable for a divide-by-two mode and a one-cycle chip reset pulse that a host write starts. The rotation and converter datapaths sit outside the block. They supply their 12-bit results as input buses and report completion with single-cycle event strobes.

All 12-bit quantities sit in the upper 12 bits of the 16-bit host word, and the low nibble reads as zero. A host interrupt handler reads the status word to find out which source fired. That read also acknowledges the sources it reported.

Top module: `mcc_host_regs`

## Requirements
- R1: After synchronous reset the control word is 0x0000 and the status word is 0x0000. `irq_n` is 1, `rdata` is 0, `chip_rst` is 0, `clk_en` is 1, and all mode outputs are 0.
- R2: A write to address 0xD stores bits [15:4] of `wdata`. A later read of 0xD returns them with bits [3:0] zero. The mode outputs follow the stored bits: `u_en` bit 7, `aux_en` bit 8, `div2_en` bit 9, `fwd_mode` bit 14. Bit 10 enables the rotation source and bit 11 enables the conversion source.
- R3: A read of address 0..3 returns rotation result 0..3, and a read of 5..8 returns converter result 0..3. Each 12-bit value is returned as {value, 4'h0}, so 0x800 reads as 0x8000. Addresses 4, 9 to 0xC and 0xF read 0x0000.
- R4: A `conv_evt` pulse sets status bit 4 and a `rot_evt` pulse sets status bit 5, whether or not that source is enabled. Status bit 15 is 1 exactly when a set flag has its enable bit set.
- R5: `irq_n` goes low on the clock edge after the one where an enabled flag becomes pending. This also covers a flag that was already pending when its enable is written. `irq_n` stays low while an enabled flag remains pending.
- R6: A read of address 0xE returns the status word as it was before the read, then clears every flag that was set. An event strobe that arrives in the same cycle as the read stays set. `irq_n` returns high one edge after the clear.
- R7: A write to any address other than 0xD and 0xF leaves the control word unchanged.
- R8: A write to address 0xF drives `chip_rst` high for exactly one cycle. On the edge that samples that write, the control word and all flags return to zero.
- R9: `clk_en` stays 1 while control bit 9 is clear. While bit 9 is set, `clk_en` alternates every cycle.
- R10: Read data is registered and appears one cycle after the read strobe. It holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Registered host read data |
| rot_res | input | 48 | Four 12-bit rotation results, result i at bits [12i+11:12i] |
| adc_res | input | 48 | Four 12-bit converter results, same packing |
| conv_evt | input | 1 | Conversion-complete strobe |
| rot_evt | input | 1 | Rotation-complete strobe |
| irq_n | output | 1 | Active-low interrupt request |
| chip_rst | output | 1 | One-cycle reset pulse to the datapaths |
| clk_en | output | 1 | Clock enable for the coprocessor core |
| u_en | output | 1 | U-channel conversion enable |
| aux_en | output | 1 | Auxiliary channel enable |
| div2_en | output | 1 | Divide-by-two clock mode |
| fwd_mode | output | 1 | Forward rotation mode select (0 = reverse) |

## Verification
The bench reads every result address against distinct result patterns. These include the most negative 12-bit value, the most positive value, all ones and zero, so a shifted, swapped or truncated lane shows up as a wrong word. Event sequences are run with the source disabled, then enabled, then enabled after the flag is already pending, and then with an event in the same cycle as the status read. Together these separate a flag that is recorded from one that is reported, and a clear that acknowledges the flag from one that loses a new event. Writes to other addresses, the soft reset and the divide mode are each checked at the ports.

// File: rtl/mcc_regs_pkg.sv
package mcc_regs_pkg;
  // control word bit positions
  localparam int CB_UEN     = 7;
  localparam int CB_AUX     = 8;
  localparam int CB_DIV2    = 9;
  localparam int CB_ROT_IE  = 10;
  localparam int CB_CONV_IE = 11;
  localparam int CB_FWD     = 14;
  // status word bit positions
  localparam int SB_CONV    = 4;
  localparam int SB_ROT     = 5;
  localparam int SB_GLOBAL  = 15;
  // event sources: index 0 conversion, index 1 rotation
  localparam int NSRC       = 2;
  localparam int SRC_CONV   = 0;
  localparam int SRC_ROT    = 1;
  // address map
  localparam logic [3:0] A_ROT_BASE = 4'h0;
  localparam logic [3:0] A_ADC_BASE = 4'h5;
  localparam logic [3:0] A_CTRL     = 4'hD;
  localparam logic [3:0] A_STAT     = 4'hE;
  localparam logic [3:0] A_SRST     = 4'hF;
endpackage

// File: rtl/mcc_ctrl_reg.sv
module mcc_ctrl_reg
  import mcc_regs_pkg::*;
#(
  parameter int HOST_W = 16,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_clr,
  input  logic              wr_sel,
  input  logic [HOST_W-1:0] wdata,
  output logic [HOST_W-1:0] ctrl_q,
  output logic              clk_en_q
);
  localparam int PAD_W = HOST_W - DATA_W;

  logic [DATA_W-1:0] ctrl_hi;

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      ctrl_hi <= '0;
    end else if (wr_sel) begin
      ctrl_hi <= wdata[HOST_W-1:PAD_W];
    end
  end

  assign ctrl_q = {ctrl_hi, {PAD_W{1'b0}}};

  // divide-by-two enable: free-running when the mode bit is clear
  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      clk_en_q <= 1'b1;
    end else if (ctrl_q[CB_DIV2]) begin
      clk_en_q <= ~clk_en_q;
    end else begin
      clk_en_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mcc_evt_flags.sv
module mcc_evt_flags #(
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_clr,
  input  logic          rd_clr,
  input  logic [NS-1:0] evt,
  input  logic [NS-1:0] en,
  output logic [NS-1:0] flags_q,
  output logic          pend,
  output logic          irq_n_q
);
  for (genvar g = 0; g < NS; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst || soft_clr) begin
        flags_q[g] <= 1'b0;
      end else if (rd_clr) begin
        flags_q[g] <= evt[g];
      end else begin
        flags_q[g] <= flags_q[g] | evt[g];
      end
    end
  end

  assign pend = |(flags_q & en);

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      irq_n_q <= 1'b1;
    end else begin
      irq_n_q <= ~pend;
    end
  end
endmodule

// File: rtl/mcc_rd_mux.sv
module mcc_rd_mux
  import mcc_regs_pkg::*;
#(
  parameter int HOST_W = 16,
  parameter int DATA_W = 12,
  parameter int NRES   = 4,
  parameter int AW     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [NRES*DATA_W-1:0] rot_res,
  input  logic [NRES*DATA_W-1:0] adc_res,
  input  logic [HOST_W-1:0]      ctrl,
  input  logic [HOST_W-1:0]      status,
  output logic [HOST_W-1:0]      rdata_q
);
  localparam int PAD_W = HOST_W - DATA_W;

  logic [HOST_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NRES; i++) begin
      if (addr == AW'(int'(A_ROT_BASE) + i)) begin
        rd_val = {rot_res[i*DATA_W +: DATA_W], {PAD_W{1'b0}}};
      end
      if (addr == AW'(int'(A_ADC_BASE) + i)) begin
        rd_val = {adc_res[i*DATA_W +: DATA_W], {PAD_W{1'b0}}};
      end
    end
    if (addr == AW'(A_CTRL)) rd_val = ctrl;
    if (addr == AW'(A_STAT)) rd_val = status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_val;
    end
  end
endmodule

// File: rtl/mcc_host_regs.sv
module mcc_host_regs
  import mcc_regs_pkg::*;
#(
  parameter int HOST_W = 16,
  parameter int DATA_W = 12,
  parameter int NRES   = 4,
  parameter int AW     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [AW-1:0]          addr,
  input  logic                   rd_en,
  input  logic                   wr_en,
  input  logic [HOST_W-1:0]      wdata,
  output logic [HOST_W-1:0]      rdata,
  input  logic [NRES*DATA_W-1:0] rot_res,
  input  logic [NRES*DATA_W-1:0] adc_res,
  input  logic                   conv_evt,
  input  logic                   rot_evt,
  output logic                   irq_n,
  output logic                   chip_rst,
  output logic                   clk_en,
  output logic                   u_en,
  output logic                   aux_en,
  output logic                   div2_en,
  output logic                   fwd_mode
);
  logic              ctrl_hit, srst_hit, stat_rd;
  logic [HOST_W-1:0] ctrl_w, status_w;
  logic [NSRC-1:0]   evt_w, en_w, flags_w;
  logic              pend_w;

  assign ctrl_hit = wr_en && (addr == AW'(A_CTRL));
  assign srst_hit = wr_en && (addr == AW'(A_SRST));
  assign stat_rd  = rd_en && (addr == AW'(A_STAT));

  mcc_ctrl_reg #(.HOST_W(HOST_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .soft_clr (srst_hit),
    .wr_sel   (ctrl_hit),
    .wdata    (wdata),
    .ctrl_q   (ctrl_w),
    .clk_en_q (clk_en)
  );

  assign evt_w[SRC_CONV] = conv_evt;
  assign evt_w[SRC_ROT]  = rot_evt;
  assign en_w[SRC_CONV]  = ctrl_w[CB_CONV_IE];
  assign en_w[SRC_ROT]   = ctrl_w[CB_ROT_IE];

  mcc_evt_flags #(.NS(NSRC)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .soft_clr (srst_hit),
    .rd_clr   (stat_rd),
    .evt      (evt_w),
    .en       (en_w),
    .flags_q  (flags_w),
    .pend     (pend_w),
    .irq_n_q  (irq_n)
  );

  always_comb begin
    status_w            = '0;
    status_w[SB_CONV]   = flags_w[SRC_CONV];
    status_w[SB_ROT]    = flags_w[SRC_ROT];
    status_w[SB_GLOBAL] = pend_w;
  end

  mcc_rd_mux #(.HOST_W(HOST_W), .DATA_W(DATA_W), .NRES(NRES), .AW(AW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .rot_res (rot_res),
    .adc_res (adc_res),
    .ctrl    (ctrl_w),
    .status  (status_w),
    .rdata_q (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) chip_rst <= 1'b0;
    else     chip_rst <= srst_hit;
  end

  assign u_en     = ctrl_w[CB_UEN];
  assign aux_en   = ctrl_w[CB_AUX];
  assign div2_en  = ctrl_w[CB_DIV2];
  assign fwd_mode = ctrl_w[CB_FWD];
endmodule

// File: rtl/mcc_host_regs_chk.sv
module mcc_host_regs_chk #(
  parameter int HOST_W = 16,
  parameter int AW     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [AW-1:0]     addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [HOST_W-1:0] rdata,
  input logic              irq_n,
  input logic              chip_rst,
  input logic              clk_en,
  input logic              u_en,
  input logic              aux_en,
  input logic              div2_en,
  input logic              fwd_mode
);
  logic srst_wr;
  assign srst_wr = wr_en && (addr == AW'(4'hF));

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (irq_n && !chip_rst && clk_en && rdata == '0 &&
             !u_en && !aux_en && !div2_en && !fwd_mode));

  a_r8_srst_pulse: assert property (@(posedge clk) disable iff (rst)
    srst_wr |=> chip_rst);

  a_r8_srst_only: assert property (@(posedge clk) disable iff (rst)
    !srst_wr |=> !chip_rst);

  a_r9_clken_full: assert property (@(posedge clk) disable iff (rst)
    !div2_en |=> clk_en);

  a_r9_clken_toggle: assert property (@(posedge clk) disable iff (rst)
    (div2_en && !srst_wr) |=> (clk_en != $past(clk_en)));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind mcc_host_regs mcc_host_regs_chk #(.HOST_W(HOST_W), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .rdata    (rdata),
  .irq_n    (irq_n),
  .chip_rst (chip_rst),
  .clk_en   (clk_en),
  .u_en     (u_en),
  .aux_en   (aux_en),
  .div2_en  (div2_en),
  .fwd_mode (fwd_mode)
);

// File: tb/sim_mcc_host_regs.sv
`timescale 1ns/1ps
module sim_mcc_host_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [47:0] rot_res, adc_res;
  logic        conv_evt = 1'b0, rot_evt = 1'b0;
  logic        irq_n, chip_rst, clk_en, u_en, aux_en, div2_en, fwd_mode;

  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  assign rot_res = {12'h001, 12'h7FF, 12'h123, 12'h800};
  assign adc_res = {12'h000, 12'hFFF, 12'h456, 12'hABC};

  mcc_host_regs u0 (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .rot_res(rot_res), .adc_res(adc_res),
    .conv_evt(conv_evt), .rot_evt(rot_evt), .irq_n(irq_n),
    .chip_rst(chip_rst), .clk_en(clk_en), .u_en(u_en), .aux_en(aux_en),
    .div2_en(div2_en), .fwd_mode(fwd_mode)
  );

  // read vectors: {address, expected word}
  localparam logic [19:0] RD_VEC [12] = '{
    {4'h0, 16'h8000}, {4'h1, 16'h1230}, {4'h2, 16'h7FF0}, {4'h3, 16'h0010},
    {4'h5, 16'hABC0}, {4'h6, 16'h4560}, {4'h7, 16'hFFF0}, {4'h8, 16'h0000},
    {4'h4, 16'h0000}, {4'h9, 16'h0000}, {4'hC, 16'h0000}, {4'hF, 16'h0000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse_conv();
    @(negedge clk); conv_evt = 1'b1;
    @(negedge clk); conv_evt = 1'b0;
  endtask

  task automatic pulse_rot();
    @(negedge clk); rot_evt = 1'b1;
    @(negedge clk); rot_evt = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    logic        c0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_n", {15'd0, irq_n}, 16'h1);
    check("R1 rdata", rdata, 16'h0);
    check("R1 modes", {12'd0, u_en, aux_en, div2_en, fwd_mode}, 16'h0);
    check("R1 clk_en/chip_rst", {14'd0, clk_en, chip_rst}, 16'h2);
    do_read(4'hD, v); check("R1 ctrl", v, 16'h0);
    do_read(4'hE, v); check("R1 status", v, 16'h0);

    // R3 result lanes via vector table
    for (int i = 0; i < 12; i++) begin
      do_read(RD_VEC[i][19:16], v);
      check($sformatf("R3 addr %h", RD_VEC[i][19:16]), v, RD_VEC[i][15:0]);
    end

    // R2 control write/readback and mode bits
    do_write(4'hD, 16'h4F8F);
    do_read(4'hD, v); check("R2 ctrl readback", v, 16'h4F80);
    check("R2 modes", {12'd0, u_en, aux_en, div2_en, fwd_mode}, 16'hF);
    // R9 alternation while divide mode set
    c0 = clk_en; @(negedge clk);
    check("R9 toggle", {15'd0, clk_en}, {15'd0, ~c0});
    c0 = clk_en; @(negedge clk);
    check("R9 toggle 2", {15'd0, clk_en}, {15'd0, ~c0});
    do_write(4'hD, 16'h0000);
    idle(1);
    check("R9 steady a", {15'd0, clk_en}, 16'h1);
    idle(1);
    check("R9 steady b", {15'd0, clk_en}, 16'h1);

    // R7 writes elsewhere ignored
    do_write(4'h2, 16'hFFFF);
    do_write(4'hE, 16'hFFFF);
    do_write(4'h9, 16'hFFFF);
    do_read(4'hD, v); check("R7 ctrl untouched", v, 16'h0);
    check("R7 modes", {12'd0, u_en, aux_en, div2_en, fwd_mode}, 16'h0);

    // R4 disabled source still recorded, no interrupt
    pulse_conv(); idle(1);
    check("R5 disabled no irq", {15'd0, irq_n}, 16'h1);
    do_read(4'hE, v); check("R4 disabled flag", v, 16'h0010);
    do_read(4'hE, v); check("R6 cleared", v, 16'h0000);

    // R5 enabled source latency and hold
    do_write(4'hD, 16'h0800);
    pulse_conv();
    check("R5 not yet", {15'd0, irq_n}, 16'h1);
    idle(1);
    check("R5 asserted", {15'd0, irq_n}, 16'h0);
    idle(3);
    check("R5 held", {15'd0, irq_n}, 16'h0);
    do_read(4'hE, v); check("R4 enabled status", v, 16'h8010);
    idle(1);
    check("R6 irq released", {15'd0, irq_n}, 16'h1);

    // R5 pending flag then enable
    do_write(4'hD, 16'h0000);
    pulse_rot(); idle(2);
    check("R5 pending disabled", {15'd0, irq_n}, 16'h1);
    do_write(4'hD, 16'h0400); idle(1);
    check("R5 late enable", {15'd0, irq_n}, 16'h0);
    do_read(4'hE, v); check("R4 rot status", v, 16'h8020);

    // R6 event arriving with the status read survives
    do_write(4'hD, 16'h0C00);
    pulse_conv();
    @(negedge clk); rd_en = 1'b1; addr = 4'hE; rot_evt = 1'b1;
    @(negedge clk); rd_en = 1'b0; rot_evt = 1'b0; v = rdata;
    check("R6 snapshot", v, 16'h8010);
    do_read(4'hE, v); check("R6 survivor", v, 16'h8020);

    // R8 soft reset
    do_write(4'hD, 16'h4C80);
    pulse_conv();
    @(negedge clk); wr_en = 1'b1; addr = 4'hF; wdata = 16'h0;
    @(negedge clk); wr_en = 1'b0;
    check("R8 pulse high", {15'd0, chip_rst}, 16'h1);
    @(negedge clk);
    check("R8 pulse low", {15'd0, chip_rst}, 16'h0);
    check("R8 irq_n", {15'd0, irq_n}, 16'h1);
    do_read(4'hD, v); check("R8 ctrl cleared", v, 16'h0);
    do_read(4'hE, v); check("R8 flags cleared", v, 16'h0);

    // R10 read data holds without a read
    do_read(4'h1, v);
    @(negedge clk); addr = 4'h6;
    idle(3);
    check("R10 hold", rdata, 16'h1230);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule